// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller turns a single-beat request port (address, read/write flag, write data, valid/ready) into the control strobes of one asynchronous DRAM device: an active-low row strobe, an active-low column strobe, an active-low write enable and a shared row/column address bus. The first access to a row presents the row address under the row strobe and then the column address under the column strobe. The row is then left open, so a later request to the same row costs only a new column strobe.

Reads and writes may follow each other in any order while a row is open. A request to another row closes the open row with a precharge period before opening the new row. The row is also closed, and the controller returns to idle, once a fixed number of column accesses has been made in it. Read data is sampled from the device at the end of the column strobe and handed back with a one-cycle valid pulse. All strobe widths are whole clock counts set by parameters.

Top module: `dpm_page_ctrl`

## Requirements
- R1: A request accepted while no row is open drives the row strobe low with the row field on the address bus for T_RCD cycles, starting the cycle after acceptance, and then drives the column strobe low with the column field for T_CAS cycles, with the row strobe still low.
- R2: After each column strobe the row strobe stays low; the column strobe goes high for at least T_CASH cycles and stays high until the next column strobe of the same row.
- R3: A request whose row field equals the open row, accepted while the row is open, starts its column strobe in the cycle after acceptance and puts no row address on the bus.
- R4: During the column strobe of a write the write enable is low, the data output enable is high and the data output carries the request's write data; during a read strobe the write enable is high and the output enable low. Reads and writes may be mixed in one open row.
- R5: When the MAX_HITS-th column access of an open row completes, the row strobe goes high for T_PRE cycles after the column high time and the controller returns to idle, so the next request pays the full row-then-column latency.
- R6: A request to a row other than the open one drives the row strobe high for T_PRE cycles, then opens the new row as in R1 and performs the access.
- R7: For a read, the data on the device input during the last column-strobe cycle appears on the response data output together with a response valid pulse exactly one cycle long, in the cycle after the strobe ends; writes give no response pulse.
- R8: Request ready is high only while idle or while a row is open and waiting; it is low during the row delay, the column strobe, the column high time and the precharge.
- R9: During reset the row, column and write strobes are high, the output enable and response valid are low and request ready is high.
- R10: The request address splits with the column in its low COL_W bits and the row in the ROW_W bits above them; the address bus carries each right-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row above column |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_dq_out | output | DATA_W | Data to the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
The hardest state to reach is the forced close after MAX_HITS accesses in one row, because any request to another row closes the row earlier and resets the count. The stimulus therefore opens a fresh row and issues more than MAX_HITS back-to-back requests to that row with alternating reads and writes and varying columns, so the limit is reached mid-stream and the requests that follow must reopen the same row through the full row delay. Row changes, a row and column of all ones, and idle gaps while the row is open are exercised before that run.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RCD,
      ST_CAS,
      ST_CASH,
      ST_OPEN,
      ST_PRE
   } dpm_state_e;

endpackage

// File: rtl/dpm_timer.sv
module dpm_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/dpm_hit_cnt.sv
module dpm_hit_cnt #(
   parameter int MAX_HITS = 200,
   localparam int HIT_W = $clog2(MAX_HITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [HIT_W-1:0] cnt,
   output logic             at_limit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (inc && !at_limit) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign at_limit = (cnt == HIT_W'(MAX_HITS));

   // R5
   hit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= HIT_W'(MAX_HITS));

endmodule

// File: rtl/dpm_addr_split.sv
module dpm_addr_split #(
   parameter int ROW_W = 10,
   parameter int COL_W = 10,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ROW_W-1:0]  open_row,
   input  logic              open_vld,
   input  logic [ROW_W-1:0]  lat_row,
   input  logic [COL_W-1:0]  lat_col,
   output logic [ROW_W-1:0]  req_row,
   output logic [COL_W-1:0]  req_col,
   output logic              row_hit,
   output logic [MUX_W-1:0]  row_bus,
   output logic [COL_W-1:0]  col_raw,
   output logic [MUX_W-1:0]  col_bus
);

   assign req_col = req_addr[COL_W-1:0];
   assign req_row = req_addr[ADDR_W-1:COL_W];
   assign row_hit = open_vld && (req_row == open_row);
   assign col_raw = lat_col;

   generate
      if (ROW_W == COL_W) begin : g_same
         assign row_bus = lat_row;
         assign col_bus = lat_col;
      end else if (ROW_W > COL_W) begin : g_row_wide
         assign row_bus = lat_row;
         assign col_bus = {{(ROW_W - COL_W){1'b0}}, lat_col};
      end else begin : g_col_wide
         assign row_bus = {{(COL_W - ROW_W){1'b0}}, lat_row};
         assign col_bus = lat_col;
      end
   endgenerate

endmodule

// File: rtl/dpm_page_ctrl.sv
module dpm_page_ctrl
   import dpm_pkg::*;
#(
   parameter int ROW_W    = 10,
   parameter int COL_W    = 10,
   parameter int DATA_W   = 16,
   parameter int T_RCD    = 2,
   parameter int T_CAS    = 2,
   parameter int T_CASH   = 1,
   parameter int T_PRE    = 2,
   parameter int MAX_HITS = 200
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   output logic                                      req_ready,
   input  logic                                      req_write,
   input  logic [ROW_W+COL_W-1:0]                    req_addr,
   input  logic [DATA_W-1:0]                         req_wdata,
   output logic                                      rsp_valid,
   output logic [DATA_W-1:0]                         rsp_rdata,
   output logic                                      dram_ras_n,
   output logic                                      dram_cas_n,
   output logic                                      dram_we_n,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic [DATA_W-1:0]                         dram_dq_out,
   output logic                                      dram_dq_oe,
   input  logic [DATA_W-1:0]                         dram_dq_in
);

   localparam int ADDR_W = ROW_W + COL_W;
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int T_M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
   localparam int T_M2   = (T_CASH > T_PRE) ? T_CASH : T_PRE;
   localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
   localparam int CNT_W  = $clog2(T_MAX + 1);
   localparam int HIT_W  = $clog2(MAX_HITS + 1);

   // elaboration-time parameter checks
   if (T_RCD < 1 || T_CAS < 1 || T_CASH < 1 || T_PRE < 1) begin : g_bad_timing
      $error("dpm_page_ctrl: every strobe timing must be at least one cycle");
   end
   if (MAX_HITS < 1) begin : g_bad_hits
      $error("dpm_page_ctrl: MAX_HITS must be at least one");
   end
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dpm_page_ctrl: address and data widths must be positive");
   end

   dpm_state_e        st, st_nxt;
   logic              accept;
   logic              pend;
   logic [ROW_W-1:0]  open_row;
   logic              open_vld;
   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;
   logic              lat_wr;
   logic [DATA_W-1:0] lat_wdata;
   logic [ROW_W-1:0]  req_row;
   logic [COL_W-1:0]  req_col;
   logic              row_hit;
   logic [MUX_W-1:0]  row_bus;
   logic [COL_W-1:0]  col_raw;
   logic [MUX_W-1:0]  col_bus;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_exp;
   logic              hit_clr;
   logic              hit_inc;
   logic [HIT_W-1:0]  hit_cnt;
   logic              hit_at_lim;
   logic              row_open_go;

   dpm_addr_split #(
      .ROW_W (ROW_W),
      .COL_W (COL_W)
   ) i_split (
      .req_addr (req_addr),
      .open_row (open_row),
      .open_vld (open_vld),
      .lat_row  (lat_row),
      .lat_col  (lat_col),
      .req_row  (req_row),
      .req_col  (req_col),
      .row_hit  (row_hit),
      .row_bus  (row_bus),
      .col_raw  (col_raw),
      .col_bus  (col_bus)
   );

   dpm_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   dpm_hit_cnt #(
      .MAX_HITS (MAX_HITS)
   ) i_hits (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (hit_clr),
      .inc      (hit_inc),
      .cnt      (hit_cnt),
      .at_limit (hit_at_lim)
   );

   // next-state selection
   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_IDLE: if (req_valid) st_nxt = ST_RCD;
         ST_RCD:  if (tmr_exp) st_nxt = ST_CAS;
         ST_CAS:  if (tmr_exp) st_nxt = ST_CASH;
         ST_CASH: if (tmr_exp) st_nxt = hit_at_lim ? ST_PRE : ST_OPEN;
         ST_OPEN: if (req_valid) st_nxt = row_hit ? ST_CAS : ST_PRE;
         ST_PRE:  if (tmr_exp) st_nxt = pend ? ST_RCD : ST_IDLE;
         default: st_nxt = ST_IDLE;
      endcase
   end

   // phase timer loads on every state change
   always_comb begin
      tmr_load = (st_nxt != st);
      unique case (st_nxt)
         ST_RCD:  tmr_val = CNT_W'(T_RCD - 1);
         ST_CAS:  tmr_val = CNT_W'(T_CAS - 1);
         ST_CASH: tmr_val = CNT_W'(T_CASH - 1);
         ST_PRE:  tmr_val = CNT_W'(T_PRE - 1);
         default: tmr_val = '0;
      endcase
   end

   assign req_ready   = (st == ST_IDLE) || (st == ST_OPEN);
   assign accept      = req_valid && req_ready;
   assign row_open_go = (st == ST_IDLE && accept) || (st == ST_PRE && tmr_exp && pend);
   assign hit_clr     = row_open_go;
   assign hit_inc     = (st == ST_CAS) && tmr_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         pend      <= 1'b0;
         open_row  <= '0;
         open_vld  <= 1'b0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wr    <= 1'b0;
         lat_wdata <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         st <= st_nxt;
         if (accept) begin
            lat_row   <= req_row;
            lat_col   <= req_col;
            lat_wr    <= req_write;
            lat_wdata <= req_wdata;
         end
         if (st == ST_OPEN && accept && !row_hit) begin
            pend <= 1'b1;
         end else if (st == ST_PRE && tmr_exp) begin
            pend <= 1'b0;
         end
         if (st == ST_IDLE && accept) begin
            open_row <= req_row;
            open_vld <= 1'b1;
         end else if (st == ST_PRE && tmr_exp && pend) begin
            open_row <= lat_row;
            open_vld <= 1'b1;
         end else if (st_nxt == ST_PRE && st != ST_PRE) begin
            open_vld <= 1'b0;
         end
         rsp_valid <= hit_inc && !lat_wr;
         if (hit_inc && !lat_wr) begin
            rsp_rdata <= dram_dq_in;
         end
      end
   end

   // device pins decoded from the phase
   always_comb begin
      dram_ras_n  = !(st == ST_RCD || st == ST_CAS || st == ST_CASH || st == ST_OPEN);
      dram_cas_n  = (st != ST_CAS);
      dram_we_n   = !(st == ST_CAS && lat_wr);
      dram_dq_oe  = (st == ST_CAS) && lat_wr;
      dram_dq_out = lat_wdata;
      unique case (st)
         ST_RCD:           dram_addr = row_bus;
         ST_CAS, ST_CASH:  dram_addr = col_bus;
         default:          dram_addr = '0;
      endcase
   end

   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !req_ready);

   // R2
   cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   // R4
   we_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> !dram_cas_n);

   // R7
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R3
   page_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OPEN && req_valid && row_hit) |=> !dram_cas_n);

   // R10
   col_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n) |-> (dram_addr[COL_W-1:0] == col_raw));

endmodule

// File: tb/test_dpm_page_ctrl.sv
module test_dpm_page_ctrl;

   localparam int ROW_W    = 10;
   localparam int COL_W    = 10;
   localparam int DATA_W   = 16;
   localparam int T_RCD    = 2;
   localparam int T_CAS    = 2;
   localparam int T_CASH   = 1;
   localparam int T_PRE    = 2;
   localparam int MAX_HITS = 200;
   localparam int ADDR_W   = ROW_W + COL_W;
   localparam int MUX_W    = (ROW_W > COL_W) ? ROW_W : COL_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic              dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [MUX_W-1:0]  dram_addr;
   logic [DATA_W-1:0] dram_dq_out;
   logic [DATA_W-1:0] dram_dq_in;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   bit live   = 1'b0;

   always #2 clk = ~clk;

   dpm_page_ctrl #(
      .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
      .T_RCD (T_RCD), .T_CAS (T_CAS), .T_CASH (T_CASH), .T_PRE (T_PRE),
      .MAX_HITS (MAX_HITS)
   ) i_dpm_page_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n),
      .dram_addr (dram_addr), .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe),
      .dram_dq_in (dram_dq_in)
   );

   function automatic logic [DATA_W-1:0] hv(input int a);
      return DATA_W'(a * 37 + 4660);
   endfunction

   // device model: read data depends on the column on the bus
   assign dram_dq_in = (!dram_cas_n && dram_we_n) ? hv(int'(dram_addr)) : '0;

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
      end
   endtask

   // reference model: 0 idle, 1 row delay, 2 column strobe, 3 column high, 4 open, 5 precharge
   int m_ph, m_left, m_hits, m_row, m_lrow, m_lcol;
   bit m_pend, m_lwr, m_rsp;
   logic [DATA_W-1:0] m_lwd, m_rdat;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_hits = 0; m_row = 0; m_lrow = 0; m_lcol = 0;
         m_pend = 0; m_lwr = 0; m_rsp = 0; m_lwd = '0; m_rdat = '0;
      end else begin
         bit acc;
         acc = req_valid && (m_ph == 0 || m_ph == 4);
         m_rsp = 0;
         if (acc) begin
            m_lcol = int'(req_addr) % (1 << COL_W);
            m_lrow = int'(req_addr) / (1 << COL_W);
            m_lwr  = req_write;
            m_lwd  = req_wdata;
         end
         case (m_ph)
            0: if (acc) begin m_row = m_lrow; m_hits = 0; m_ph = 1; m_left = T_RCD; end
            1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = T_CAS; end end
            2: begin
               m_left--;
               if (m_left == 0) begin
                  m_hits++;
                  if (!m_lwr) begin m_rsp = 1; m_rdat = hv(m_lcol); end
                  m_ph = 3; m_left = T_CASH;
               end
            end
            3: begin
               m_left--;
               if (m_left == 0) begin
                  if (m_hits == MAX_HITS) begin m_pend = 0; m_ph = 5; m_left = T_PRE; end
                  else m_ph = 4;
               end
            end
            4: if (acc) begin
               if (m_lrow == m_row) begin m_ph = 2; m_left = T_CAS; end
               else begin m_pend = 1; m_ph = 5; m_left = T_PRE; end
            end
            default: begin
               m_left--;
               if (m_left == 0) begin
                  if (m_pend) begin m_row = m_lrow; m_hits = 0; m_ph = 1; m_left = T_RCD; m_pend = 0; end
                  else m_ph = 0;
               end
            end
         endcase
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (live && rst_n) begin
         string t_str;
         logic [31:0] e_addr;
         case (m_ph)
            1: t_str = (m_hits == 0 && cyc > 0) ? "R1" : "R6";
            2: t_str = "R3";
            3, 4: t_str = "R2";
            5: t_str = m_pend ? "R6" : "R5";
            default: t_str = "R8";
         endcase
         e_addr = (m_ph == 1) ? 32'(m_lrow) : (m_ph == 2 || m_ph == 3) ? 32'(m_lcol) : 32'd0;
         chk(t_str, "ras_n", 32'(dram_ras_n), 32'(!(m_ph >= 1 && m_ph <= 4)));
         chk(t_str, "cas_n", 32'(dram_cas_n), 32'(m_ph != 2));
         chk("R10", "addr", 32'(dram_addr), e_addr);
         chk("R4", "we_n", 32'(dram_we_n), 32'(!(m_ph == 2 && m_lwr)));
         chk("R4", "dq_oe", 32'(dram_dq_oe), 32'(m_ph == 2 && m_lwr));
         if (m_ph == 2 && m_lwr) chk("R4", "dq_out", 32'(dram_dq_out), 32'(m_lwd));
         chk("R8", "ready", 32'(req_ready), 32'(m_ph == 0 || m_ph == 4));
         chk("R7", "rsp_valid", 32'(rsp_valid), 32'(m_rsp));
         if (m_rsp) chk("R7", "rsp_rdata", 32'(rsp_rdata), 32'(m_rdat));
      end
   end

   task automatic do_req(input bit wr, input int row, input int col, input int wd);
      req_write = wr;
      req_addr  = ADDR_W'((row << COL_W) | col);
      req_wdata = DATA_W'(wd);
      req_valid = 1'b1;
      forever begin
         if (req_ready) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "ras_n", 32'(dram_ras_n), 32'd1);
      chk("R9", "cas_n", 32'(dram_cas_n), 32'd1);
      chk("R9", "we_n", 32'(dram_we_n), 32'd1);
      chk("R9", "dq_oe", 32'(dram_dq_oe), 32'd0);
      chk("R9", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R9", "ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      live  = 1'b1;
      @(negedge clk);
      // R1 first access, R3 page hits, R4 mixed reads and writes
      do_req(0, 5, 10, 0);
      do_req(0, 5, 11, 0);
      do_req(1, 5, 12, 16'hA5C3);
      do_req(0, 5, 1023, 0);
      repeat (5) @(negedge clk);
      do_req(1, 5, 0, 16'h0F0F);
      // R6 row change, R10 all-ones fields
      do_req(0, 9, 7, 0);
      do_req(1, 1023, 1023, 16'hFFFF);
      do_req(0, 1023, 512, 0);
      // R5 access limit inside one row, then reopen
      for (int i = 0; i < MAX_HITS + 5; i++) begin
         do_req(i[0], 3, (i * 5) % 1024, i * 3 + 1);
      end
      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule